// File: doc/BRIEF.md
# Branch and Next-PC Unit

This block works out where a word-addressed core fetches next. For each instruction it receives the current program counter, the first source value, the second operand (already chosen by the caller as either a register or a zero-extended 8-bit immediate), a signed relative offset, a 16-bit jump immediate and a branch opcode. It produces the next program counter. For jump-and-link it also produces a return value with its own write strobe.

Supported flows are: unsigned compare branches, an unconditional relative branch, single-bit test branches and absolute jumps, with or without a link. Every compare uses the second operand as its left-hand side and the first source as its right-hand side. Opcodes that are not branches step to the next word. Each request is registered, so results appear one clock after `inValid`. Loop hardware and instruction fetch sit outside this block.

Top module: `brn_unit`

## Requirements
- R1: While `rst_n` is low, and after reset until the first request, `outValid`, `nextPc`, `linkValue` and `linkWe` are all zero.
- R2: `outValid` is high exactly one cycle after a cycle with `inValid` high. When `inValid` is low, `nextPc` and `linkValue` keep their previous values.
- R3: The ordered compares are unsigned and use `opnd2` on the left. Opcode 1 is taken when opnd2 > src1, opcode 2 when opnd2 >= src1, opcode 3 when opnd2 < src1 and opcode 4 when opnd2 <= src1.
- R4: Opcode 5 is taken when opnd2 equals src1. Opcode 6 is taken when they differ.
- R5: A taken conditional branch gives `curPc` plus `brOffset`, with the offset sign-extended and the sum wrapping modulo 2^PC_W. A branch that is not taken gives `curPc + 1`.
- R6: Opcode 7 always gives `curPc + brOffset`, whatever the operands are.
- R7: Opcode 8 is taken when bit `opnd2[4:0]` of `src1` is 1. Opcode 9 is taken when that bit is 0. The upper bits of `opnd2` are ignored.
- R8: Opcode 10 loads `nextPc` with `imm16` when `jmpImm` is 1, and with the low PC_W bits of `opnd2` when `jmpImm` is 0.
- R9: Opcode 11 jumps like opcode 10 and also puts out `linkValue = curPc + 1` with `linkWe` high. `linkWe` is high only in a result cycle of opcode 11.
- R10: Opcode 0 and the unused codes 12 to 15 give `curPc + 1` with `linkWe` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Request present this cycle |
| opcode | input | 4 | Branch operation code |
| curPc | input | 16 | Current word address |
| src1 | input | 32 | First source value |
| opnd2 | input | 32 | Second operand (register or immediate) |
| brOffset | input | 10 | Signed relative offset in words |
| imm16 | input | 16 | Absolute jump immediate |
| jmpImm | input | 1 | Jump target from imm16 (1) or opnd2 (0) |
| outValid | output | 1 | Result present |
| nextPc | output | 16 | Computed next word address |
| linkValue | output | 16 | Return address for jump-and-link |
| linkWe | output | 1 | Link register write enable |

## Verification
A decode error or a flipped compare flag inside the block reaches the ports one cycle after the request. It shows as a `nextPc` of `curPc + 1` where a target was expected, or the reverse. Operand order and signedness are exercised with values whose result changes if either is wrong, such as an all-ones `opnd2`. A wrongly gated link strobe shows as `linkWe` high in the same result cycle of a non-link opcode, or high in an idle cycle. A bad hold path shows as `nextPc` moving while no request is present.

// File: rtl/brn_pkg.sv
package brn_pkg;

  localparam logic [3:0] OP_SEQ    = 4'd0;
  localparam logic [3:0] OP_GT     = 4'd1;
  localparam logic [3:0] OP_GE     = 4'd2;
  localparam logic [3:0] OP_LT     = 4'd3;
  localparam logic [3:0] OP_LE     = 4'd4;
  localparam logic [3:0] OP_EQ     = 4'd5;
  localparam logic [3:0] OP_NE     = 4'd6;
  localparam logic [3:0] OP_ALWAYS = 4'd7;
  localparam logic [3:0] OP_BSET   = 4'd8;
  localparam logic [3:0] OP_BCLR   = 4'd9;
  localparam logic [3:0] OP_JMP    = 4'd10;
  localparam logic [3:0] OP_JAL    = 4'd11;

  // strobes from control to datapath
  typedef struct packed {
    logic takeRel;
    logic takeAbs;
    logic doLink;
  } pcStrobe_t;

  // operand relations reported by datapath
  typedef struct packed {
    logic gt;      // opnd2 > src1, unsigned
    logic eq;      // opnd2 == src1
    logic bitHit;  // selected bit of src1 is one
  } cmpFlag_t;

endpackage

// File: rtl/brn_ctrl.sv
module brn_ctrl
  import brn_pkg::*;
(
  input  logic [3:0] opcode,
  input  cmpFlag_t   flags,
  output pcStrobe_t  strobe
);

  logic condTaken;

  always_comb begin
    condTaken = 1'b0;
    unique case (opcode)
      OP_GT:     condTaken = flags.gt;
      OP_GE:     condTaken = flags.gt | flags.eq;
      OP_LT:     condTaken = ~flags.gt & ~flags.eq;
      OP_LE:     condTaken = ~flags.gt;
      OP_EQ:     condTaken = flags.eq;
      OP_NE:     condTaken = ~flags.eq;
      OP_ALWAYS: condTaken = 1'b1;
      OP_BSET:   condTaken = flags.bitHit;
      OP_BCLR:   condTaken = ~flags.bitHit;
      default:   condTaken = 1'b0;
    endcase
  end

  always_comb begin
    strobe.takeRel = condTaken;
    strobe.takeAbs = (opcode == OP_JMP) || (opcode == OP_JAL);
    strobe.doLink  = (opcode == OP_JAL);
  end

endmodule

// File: rtl/brn_datapath.sv
module brn_datapath
  import brn_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int DATA_W = 32,
  parameter int OFF_W  = 10,
  parameter int IMM_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inValid,
  input  logic [PC_W-1:0]   curPc,
  input  logic [DATA_W-1:0] src1,
  input  logic [DATA_W-1:0] opnd2,
  input  logic [OFF_W-1:0]  brOffset,
  input  logic [IMM_W-1:0]  imm16,
  input  logic              jmpImm,
  input  pcStrobe_t         strobe,
  output cmpFlag_t          flags,
  output logic              outValid,
  output logic [PC_W-1:0]   nextPc,
  output logic [PC_W-1:0]   linkValue,
  output logic              linkWe
);

  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [PC_W-1:0] PC_ONE = {{(PC_W-1){1'b0}}, 1'b1};

  logic [IDX_W-1:0] bitIdx;
  logic [PC_W-1:0]  offExt;
  logic [PC_W-1:0]  immTarget;
  logic [PC_W-1:0]  regTarget;
  logic [PC_W-1:0]  pcPlusOne;
  logic [PC_W-1:0]  pcPlusOff;
  logic [PC_W-1:0]  nextPcD;

  // operand relations
  assign bitIdx       = opnd2[IDX_W-1:0];
  assign flags.gt     = opnd2 > src1;
  assign flags.eq     = opnd2 == src1;
  assign flags.bitHit = src1[bitIdx];

  // offset sign extension sized to the PC
  generate
    if (OFF_W >= PC_W) begin : g_offTrunc
      assign offExt = brOffset[PC_W-1:0];
    end else begin : g_offExt
      assign offExt = {{(PC_W-OFF_W){brOffset[OFF_W-1]}}, brOffset};
    end
  endgenerate

  // absolute targets sized to the PC
  generate
    if (IMM_W >= PC_W) begin : g_immTrunc
      assign immTarget = imm16[PC_W-1:0];
    end else begin : g_immExt
      assign immTarget = {{(PC_W-IMM_W){1'b0}}, imm16};
    end
    if (DATA_W >= PC_W) begin : g_regTrunc
      assign regTarget = opnd2[PC_W-1:0];
    end else begin : g_regExt
      assign regTarget = {{(PC_W-DATA_W){1'b0}}, opnd2};
    end
  endgenerate

  assign pcPlusOne = curPc + PC_ONE;
  assign pcPlusOff = curPc + offExt;

  always_comb begin
    if (strobe.takeAbs)      nextPcD = jmpImm ? immTarget : regTarget;
    else if (strobe.takeRel) nextPcD = pcPlusOff;
    else                     nextPcD = pcPlusOne;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outValid  <= 1'b0;
      nextPc    <= '0;
      linkValue <= '0;
      linkWe    <= 1'b0;
    end else begin
      outValid <= inValid;
      linkWe   <= inValid & strobe.doLink;
      if (inValid) begin
        nextPc <= nextPcD;
        if (strobe.doLink) linkValue <= pcPlusOne;
      end
    end
  end

  // R2: result strobe follows the request by one cycle
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> outValid);
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> (!outValid && $stable(nextPc) && $stable(linkValue)));
  // R8: control never asks for two target kinds at once
  a_r8_one_target: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |-> $onehot0({strobe.takeRel, strobe.takeAbs}));
  // R9: link strobe only accompanies a result
  a_r9_link_gated: assert property (@(posedge clk) disable iff (!rst_n)
    linkWe |-> outValid);
  a_r9_link_value: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && strobe.doLink) |=> (linkWe && linkValue == $past(curPc) + PC_ONE));
  // R10: no target requested means sequential step
  a_r10_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && !strobe.takeRel && !strobe.takeAbs) |=> (nextPc == $past(curPc) + PC_ONE));

endmodule

// File: rtl/brn_unit.sv
module brn_unit
  import brn_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int DATA_W = 32,
  parameter int OFF_W  = 10,
  parameter int IMM_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inValid,
  input  logic [3:0]        opcode,
  input  logic [PC_W-1:0]   curPc,
  input  logic [DATA_W-1:0] src1,
  input  logic [DATA_W-1:0] opnd2,
  input  logic [OFF_W-1:0]  brOffset,
  input  logic [IMM_W-1:0]  imm16,
  input  logic              jmpImm,
  output logic              outValid,
  output logic [PC_W-1:0]   nextPc,
  output logic [PC_W-1:0]   linkValue,
  output logic              linkWe
);

  pcStrobe_t strobe;
  cmpFlag_t  flags;

  brn_ctrl u_ctrl (
    .opcode (opcode),
    .flags  (flags),
    .strobe (strobe)
  );

  brn_datapath #(
    .PC_W   (PC_W),
    .DATA_W (DATA_W),
    .OFF_W  (OFF_W),
    .IMM_W  (IMM_W)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .inValid   (inValid),
    .curPc     (curPc),
    .src1      (src1),
    .opnd2     (opnd2),
    .brOffset  (brOffset),
    .imm16     (imm16),
    .jmpImm    (jmpImm),
    .strobe    (strobe),
    .flags     (flags),
    .outValid  (outValid),
    .nextPc    (nextPc),
    .linkValue (linkValue),
    .linkWe    (linkWe)
  );

endmodule

// File: tb/brn_unit_bench.sv
module brn_unit_bench;

  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [15:0] pc;
    logic        lwe;
    logic [15:0] lval;
    string       req;
  } expItem_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inValid = 1'b0;
  logic [3:0]  opcode = '0;
  logic [15:0] curPc = '0;
  logic [31:0] src1 = '0;
  logic [31:0] opnd2 = '0;
  logic [9:0]  brOffset = '0;
  logic [15:0] imm16 = '0;
  logic        jmpImm = 1'b0;
  logic        outValid;
  logic [15:0] nextPc;
  logic [15:0] linkValue;
  logic        linkWe;

  int nCompared = 0;
  int nBad = 0;
  bit finished = 0;
  logic [15:0] lastPc = '0;
  expItem_t expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  brn_unit u_brn_unit (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .opcode(opcode),
    .curPc(curPc), .src1(src1), .opnd2(opnd2), .brOffset(brOffset),
    .imm16(imm16), .jmpImm(jmpImm), .outValid(outValid), .nextPc(nextPc),
    .linkValue(linkValue), .linkWe(linkWe)
  );

  function automatic expItem_t model(logic [3:0] op, logic [15:0] pc, logic [31:0] s1,
                                     logic [31:0] o2, logic [9:0] off, logic [15:0] imm,
                                     logic ji, string req);
    expItem_t e;
    logic tk;
    logic [15:0] rel;
    rel = pc + {{6{off[9]}}, off};
    tk = 1'b0;
    case (op)
      4'd1: tk = o2 > s1;
      4'd2: tk = o2 >= s1;
      4'd3: tk = o2 < s1;
      4'd4: tk = o2 <= s1;
      4'd5: tk = o2 == s1;
      4'd6: tk = o2 != s1;
      4'd7: tk = 1'b1;
      4'd8: tk = s1[o2[4:0]] == 1'b1;
      4'd9: tk = s1[o2[4:0]] == 1'b0;
      default: tk = 1'b0;
    endcase
    e.req = req;
    e.lwe = (op == 4'd11);
    e.lval = pc + 16'd1;
    if (op == 4'd10 || op == 4'd11) e.pc = ji ? imm : o2[15:0];
    else e.pc = tk ? rel : pc + 16'd1;
    return e;
  endfunction

  task automatic check(string req, bit ok, string what, logic [31:0] act, logic [31:0] exp);
    nCompared++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic send(logic [3:0] op, logic [15:0] pc, logic [31:0] s1, logic [31:0] o2,
                      logic [9:0] off, logic [15:0] imm, logic ji, string req);
    @(negedge clk);
    opcode = op; curPc = pc; src1 = s1; opnd2 = o2; brOffset = off;
    imm16 = imm; jmpImm = ji; inValid = 1'b1;
    expQ.push_back(model(op, pc, s1, o2, off, imm, ji, req));
  endtask

  task automatic idleCheck();
    @(negedge clk);
    inValid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    // R2: no request, result must not appear and pc must hold
    check("R2", outValid == 1'b0, "outValid idle", {31'd0, outValid}, 32'd0);
    check("R2", nextPc == lastPc, "nextPc hold", {16'd0, nextPc}, {16'd0, lastPc});
    check("R9", linkWe == 1'b0, "linkWe idle", {31'd0, linkWe}, 32'd0);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nBad);
      $finish;
    end
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && outValid) begin
        if (expQ.size() == 0) begin
          check("R2", 1'b0, "unexpected result", {16'd0, nextPc}, 32'd0);
        end else begin
          expItem_t e;
          e = expQ.pop_front();
          check(e.req, nextPc == e.pc, "nextPc", {16'd0, nextPc}, {16'd0, e.pc});
          check("R9", linkWe == e.lwe, "linkWe", {31'd0, linkWe}, {31'd0, e.lwe});
          if (e.lwe)
            check("R9", linkValue == e.lval, "linkValue", {16'd0, linkValue}, {16'd0, e.lval});
          lastPc = nextPc;
        end
      end
    end
  end

  // watchdog
  initial begin
    #(CLK_PERIOD * 150000);
    check("WDOG", 1'b0, "watchdog expired", 32'd0, 32'd1);
    finishRun();
  end

  initial begin
    #(CLK_PERIOD * 3);
    // R1: reset values
    check("R1", outValid == 1'b0, "outValid in reset", {31'd0, outValid}, 32'd0);
    check("R1", nextPc == 16'd0, "nextPc in reset", {16'd0, nextPc}, 32'd0);
    check("R1", linkWe == 1'b0 && linkValue == 16'd0, "link in reset",
          {15'd0, linkWe, linkValue}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", outValid == 1'b0 && nextPc == 16'd0, "after reset",
          {15'd0, outValid, nextPc}, 32'd0);

    // R3 ordered compares, opnd2 on the left, unsigned
    send(4'd1, 16'h0100, 32'd5, 32'd9, 10'd20, 16'h0, 1'b0, "R3");
    send(4'd1, 16'h0100, 32'd9, 32'd9, 10'd20, 16'h0, 1'b0, "R3");
    send(4'd1, 16'h0100, 32'd1, 32'hFFFF_FFFF, 10'd20, 16'h0, 1'b0, "R3");
    send(4'd2, 16'h0200, 32'd7, 32'd7, 10'd4, 16'h0, 1'b0, "R3");
    send(4'd2, 16'h0200, 32'd8, 32'd7, 10'd4, 16'h0, 1'b0, "R3");
    send(4'd3, 16'h0300, 32'd8, 32'd7, 10'd4, 16'h0, 1'b0, "R3");
    send(4'd3, 16'h0300, 32'h8000_0000, 32'h7FFF_FFFF, 10'd4, 16'h0, 1'b0, "R3");
    send(4'd3, 16'h0300, 32'd7, 32'd7, 10'd4, 16'h0, 1'b0, "R3");
    send(4'd4, 16'h0400, 32'd7, 32'd7, 10'd4, 16'h0, 1'b0, "R3");
    send(4'd4, 16'h0400, 32'd6, 32'd7, 10'd4, 16'h0, 1'b0, "R3");
    // R4 equality
    send(4'd5, 16'h0500, 32'hABCD, 32'hABCD, 10'd3, 16'h0, 1'b0, "R4");
    send(4'd5, 16'h0500, 32'hABCD, 32'hABCE, 10'd3, 16'h0, 1'b0, "R4");
    send(4'd6, 16'h0600, 32'hABCD, 32'hABCE, 10'd3, 16'h0, 1'b0, "R4");
    send(4'd6, 16'h0600, 32'hABCD, 32'hABCD, 10'd3, 16'h0, 1'b0, "R4");
    // R5 negative offset and wrap
    send(4'd5, 16'h0010, 32'd0, 32'd0, 10'h3FF, 16'h0, 1'b0, "R5");
    send(4'd5, 16'h0005, 32'd0, 32'd0, 10'h200, 16'h0, 1'b0, "R5");
    send(4'd5, 16'hFFFF, 32'd0, 32'd1, 10'd8, 16'h0, 1'b0, "R5");
    send(4'd5, 16'hFFFE, 32'd0, 32'd0, 10'd5, 16'h0, 1'b0, "R5");
    // R6 unconditional relative
    send(4'd7, 16'h0700, 32'd1, 32'd2, 10'h1F0, 16'h0, 1'b0, "R6");
    send(4'd7, 16'h0700, 32'd2, 32'd1, 10'h210, 16'h0, 1'b0, "R6");
    // R7 bit tests, upper opnd2 bits ignored
    send(4'd8, 16'h0800, 32'h0000_0020, 32'hFFFF_FF25, 10'd6, 16'h0, 1'b0, "R7");
    send(4'd8, 16'h0800, 32'hFFFF_FFDF, 32'h0000_0005, 10'd6, 16'h0, 1'b0, "R7");
    send(4'd8, 16'h0800, 32'h8000_0000, 32'h0000_001F, 10'd6, 16'h0, 1'b0, "R7");
    send(4'd9, 16'h0900, 32'hFFFF_FFFE, 32'h0000_0100, 10'd6, 16'h0, 1'b0, "R7");
    send(4'd9, 16'h0900, 32'h0000_0001, 32'h0000_0100, 10'd6, 16'h0, 1'b0, "R7");
    // R8 absolute jumps
    send(4'd10, 16'h0A00, 32'd0, 32'h1234_5678, 10'd1, 16'hBEEF, 1'b1, "R8");
    send(4'd10, 16'h0A00, 32'd0, 32'h1234_5678, 10'd1, 16'hBEEF, 1'b0, "R8");
    // R9 jump and link
    send(4'd11, 16'h0B00, 32'd0, 32'h0000_4321, 10'd1, 16'h0C0C, 1'b1, "R9");
    send(4'd11, 16'hFFFF, 32'd0, 32'h0000_4321, 10'd1, 16'h0C0C, 1'b0, "R9");
    // R10 sequential opcodes
    send(4'd0, 16'h0D00, 32'd3, 32'd3, 10'd50, 16'h1111, 1'b1, "R10");
    send(4'd12, 16'h0D10, 32'd3, 32'd3, 10'd50, 16'h1111, 1'b1, "R10");
    send(4'd15, 16'hFFFF, 32'd3, 32'd4, 10'd50, 16'h1111, 1'b1, "R10");
    idleCheck();

    // mixed stream
    for (int i = 0; i < 300; i++) begin
      send(4'($urandom_range(0, 15)), 16'($urandom), $urandom & 32'h0000_00FF,
           $urandom & 32'h0000_00FF, 10'($urandom), 16'($urandom), 1'($urandom),
           "R5");
    end
    idleCheck();

    // R1: reset mid-stream clears outputs
    send(4'd11, 16'h2222, 32'd0, 32'd0, 10'd0, 16'h3333, 1'b1, "R9");
    @(negedge clk);
    inValid = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1", outValid == 1'b0 && nextPc == 16'd0 && linkWe == 1'b0 && linkValue == 16'd0,
          "async reset", {14'd0, outValid, linkWe, nextPc}, 32'd0);
    check("R2", expQ.size() == 0, "queue drained", expQ.size(), 32'd0);
    finishRun();
  end

endmodule